// File: doc/BRIEF.md
# Bank-Aware Open-Row-First Request Picker

This block decides which pending memory request a DRAM controller serves next. It looks at a snapshot of up to `DEPTH` queued requests held in age order, where slot 0 is the oldest. Each slot carries a valid bit, a rank, a bank and a row. The block also reads per-bank state: the open row, a flag saying whether a row is open, and the time at which the bank becomes free. It further reads the current time and a mask, supplied by a companion block, of the banks that become free earliest.

In first-come mode the block returns the oldest valid slot. In open-row-first mode it walks the slots from oldest to youngest and stops at the first one that qualifies. A slot qualifies if it hits the open row of its bank, if its bank is already free, or if its bank is one of the earliest-free banks. When no slot qualifies, the oldest valid slot is chosen. The reported index is used by the queue logic to move that request to the head.

A select request is answered one clock later with a registered index and a valid flag. A combinational request output tells the companion block when the earliest-free mask is actually needed.

Top module: `req_picker`

## Requirements
- R1: `pick_vld` is high in the cycle after a cycle with `sel_req` high and at least one valid slot, and low in every other cycle after reset. `pick_idx` keeps its value when `sel_req` is low. After reset both are 0.
- R2: With `sched_mode` = 0 (first-come), the pick is the lowest-numbered valid slot. Slot 0 is the oldest.
- R3: With `sched_mode` = 1 (open-row-first), a valid slot is a row hit when its bank has its row-open flag set and that bank's open row equals the slot's row.
- R4: In open-row-first mode, a valid slot that is not a row hit still qualifies when its bank's free time is less than or equal to `now`.
- R5: In open-row-first mode, a valid slot also qualifies when bit `bank_id` of `early_mask` is set.
- R6: A slot's `bank_id` is rank × `BANKS_PER_RANK` + bank. Bit `bank_id` of `bank_row_open` and `early_mask`, and field `bank_id` of `bank_open_row` and `bank_free_at`, describe that bank.
- R7: In open-row-first mode, the lowest-numbered qualifying slot is picked, whether it qualifies by row hit or by readiness. A younger row hit never overrides an older ready slot.
- R8: In open-row-first mode, when no valid slot qualifies, the lowest-numbered valid slot is picked.
- R9: Invalid slots are never picked, even when their fields would qualify.
- R10: A bank with its row-open flag clear gives no row hit, even if its stored open row equals the slot's row.
- R11: `mask_req` is high, combinationally, exactly when `sel_req` is high, `sched_mode` = 1, and at least one valid slot is not a row hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_req | input | 1 | Evaluate the snapshot in this cycle |
| sched_mode | input | 1 | 0 = first-come, 1 = open-row-first |
| ent_valid | input | DEPTH | Per-slot valid bits, slot 0 is the oldest |
| ent_rank | input | DEPTH*RANK_W | Packed per-slot rank |
| ent_bank | input | DEPTH*BANK_W | Packed per-slot bank within its rank |
| ent_row | input | DEPTH*ROW_W | Packed per-slot row |
| bank_row_open | input | NBANK | Per-bank row-open flag, indexed by bank_id |
| bank_open_row | input | NBANK*ROW_W | Packed per-bank open row |
| bank_free_at | input | NBANK*TIME_W | Packed per-bank free time |
| now | input | TIME_W | Current time |
| early_mask | input | NBANK | Earliest-free bank mask, indexed by bank_id |
| mask_req | output | 1 | Mask is needed for this evaluation |
| pick_vld | output | 1 | Registered pick is valid |
| pick_idx | output | IDX_W | Registered index of the picked slot |

## Verification
The hardest case to reach is an older slot that qualifies only through readiness while a younger slot holds a row hit. Under uniform random fields, row hits tend to be spread over many slots, and free times rarely sit exactly at `now`. The directed cases set this up on purpose, with a hit at a high slot, a free time equal to `now` at a lower slot, and a slot that qualifies only through `early_mask` on a rank-1 bank. The random phase narrows rows to four values and places free times within a few ticks of `now`, so hits, ties and fallbacks to the head all occur many times.

// File: rtl/pick_pkg.sv
package pick_pkg;
    typedef enum logic {
        MODE_FIRST_COME = 1'b0,
        MODE_OPEN_ROW   = 1'b1
    } sched_mode_e;
endpackage

// File: rtl/slot_qualify.sv
module slot_qualify #(
    parameter int RANK_W         = 1,
    parameter int BANK_W         = 2,
    parameter int ROW_W          = 8,
    parameter int TIME_W         = 16,
    parameter int BANKS_PER_RANK = 4,
    parameter int NBANK          = 8,
    localparam int BID_W         = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic [RANK_W-1:0]       rank,
    input  logic [BANK_W-1:0]       bank,
    input  logic [ROW_W-1:0]        row,
    input  logic [NBANK-1:0]        bank_row_open,
    input  logic [NBANK*ROW_W-1:0]  bank_open_row,
    input  logic [NBANK*TIME_W-1:0] bank_free_at,
    input  logic [TIME_W-1:0]       now,
    input  logic [NBANK-1:0]        early_mask,
    output logic                    is_hit,
    output logic                    is_ready
);
    logic [BID_W-1:0]  bid;
    logic [ROW_W-1:0]  open_row;
    logic [TIME_W-1:0] free_at;

    always_comb begin
        bid      = BID_W'(int'(rank) * BANKS_PER_RANK + int'(bank));
        open_row = bank_open_row[bid*ROW_W +: ROW_W];
        free_at  = bank_free_at[bid*TIME_W +: TIME_W];
        is_hit   = bank_row_open[bid] && (open_row == row);
        is_ready = (free_at <= now) || early_mask[bid];
    end
endmodule

// File: rtl/first_set.sv
module first_set #(
    parameter int N     = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/req_picker.sv
module req_picker #(
    parameter int DEPTH          = 8,
    parameter int RANKS          = 2,
    parameter int BANKS_PER_RANK = 4,
    parameter int ROW_W          = 8,
    parameter int TIME_W         = 16,
    localparam int NBANK         = RANKS * BANKS_PER_RANK,
    localparam int RANK_W        = (RANKS > 1) ? $clog2(RANKS) : 1,
    localparam int BANK_W        = (BANKS_PER_RANK > 1) ? $clog2(BANKS_PER_RANK) : 1,
    localparam int IDX_W         = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_req,
    input  logic                    sched_mode,
    input  logic [DEPTH-1:0]        ent_valid,
    input  logic [DEPTH*RANK_W-1:0] ent_rank,
    input  logic [DEPTH*BANK_W-1:0] ent_bank,
    input  logic [DEPTH*ROW_W-1:0]  ent_row,
    input  logic [NBANK-1:0]        bank_row_open,
    input  logic [NBANK*ROW_W-1:0]  bank_open_row,
    input  logic [NBANK*TIME_W-1:0] bank_free_at,
    input  logic [TIME_W-1:0]       now,
    input  logic [NBANK-1:0]        early_mask,
    output logic                    mask_req,
    output logic                    pick_vld,
    output logic [IDX_W-1:0]        pick_idx
);
    import pick_pkg::*;

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
    } pick_t;

    pick_t st_d, st_q;

    logic [DEPTH-1:0] hit_v, ready_v, qual_v;
    logic             head_found, qual_found;
    logic [IDX_W-1:0] head_idx, qual_idx;
    sched_mode_e      mode;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        slot_qualify #(
            .RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .TIME_W(TIME_W),
            .BANKS_PER_RANK(BANKS_PER_RANK), .NBANK(NBANK)
        ) u_qual (
            .rank          (ent_rank[g*RANK_W +: RANK_W]),
            .bank          (ent_bank[g*BANK_W +: BANK_W]),
            .row           (ent_row[g*ROW_W +: ROW_W]),
            .bank_row_open (bank_row_open),
            .bank_open_row (bank_open_row),
            .bank_free_at  (bank_free_at),
            .now           (now),
            .early_mask    (early_mask),
            .is_hit        (hit_v[g]),
            .is_ready      (ready_v[g])
        );
    end

    assign qual_v = ent_valid & (hit_v | ready_v);

    first_set #(.N(DEPTH)) u_head (
        .req(ent_valid), .found(head_found), .idx(head_idx)
    );
    first_set #(.N(DEPTH)) u_qual (
        .req(qual_v), .found(qual_found), .idx(qual_idx)
    );

    always_comb begin
        mode     = sched_mode_e'(sched_mode);
        mask_req = sel_req && (mode == MODE_OPEN_ROW) && |(ent_valid & ~hit_v);
        st_d     = st_q;
        st_d.vld = sel_req && head_found;
        if (sel_req) begin
            if (mode == MODE_OPEN_ROW && qual_found)
                st_d.idx = qual_idx;
            else
                st_d.idx = head_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pick_vld = st_q.vld;
    assign pick_idx = st_q.idx;
endmodule

// File: rtl/req_picker_chk.sv
module req_picker_chk #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_req,
    input logic             sched_mode,
    input logic [DEPTH-1:0] ent_valid,
    input logic             mask_req,
    input logic             pick_vld,
    input logic [IDX_W-1:0] pick_idx
);
    logic [DEPTH-1:0] valid_q, older;
    logic             mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            mode_q  <= 1'b0;
        end else if (sel_req) begin
            valid_q <= ent_valid;
            mode_q  <= sched_mode;
        end
    end

    always_comb older = (DEPTH'(1) << pick_idx) - DEPTH'(1);

    // R1
    a_r1_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
        sel_req && |ent_valid |=> pick_vld);
    // R1
    a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_req |=> !pick_vld && $stable(pick_idx));
    // R9
    a_r9_pick_was_valid: assert property (@(posedge clk) disable iff (!rst_n)
        pick_vld |-> valid_q[pick_idx]);
    // R2
    a_r2_first_come_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        pick_vld && !mode_q |-> (valid_q & older) == '0);
    // R11
    a_r11_mask_req_scope: assert property (@(posedge clk) disable iff (!rst_n)
        mask_req |-> sel_req && sched_mode && |ent_valid);
endmodule

bind req_picker req_picker_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_req(sel_req), .sched_mode(sched_mode),
    .ent_valid(ent_valid), .mask_req(mask_req), .pick_vld(pick_vld),
    .pick_idx(pick_idx)
);

// File: tb/req_picker_test.sv
`timescale 1ns/1ps
module req_picker_test;
    localparam int DEPTH = 8, RANKS = 2, BPR = 4, ROW_W = 8, TIME_W = 16;
    localparam int NBANK = RANKS * BPR, RANK_W = 1, BANK_W = 2, IDX_W = 3;

    logic clk = 1'b0, rst_n = 1'b0, sel_req = 1'b0, sched_mode = 1'b0;
    logic [DEPTH-1:0]        ent_valid;
    logic [DEPTH*RANK_W-1:0] ent_rank;
    logic [DEPTH*BANK_W-1:0] ent_bank;
    logic [DEPTH*ROW_W-1:0]  ent_row;
    logic [NBANK-1:0]        bank_row_open, early_mask;
    logic [NBANK*ROW_W-1:0]  bank_open_row;
    logic [NBANK*TIME_W-1:0] bank_free_at;
    logic [TIME_W-1:0]       now;
    logic mask_req, pick_vld;
    logic [IDX_W-1:0] pick_idx;

    int v[DEPTH], rk[DEPTH], bk[DEPTH], rw[DEPTH];
    int bopen[NBANK], brow[NBANK], bfree[NBANK], emask[NBANK];
    int tnow;
    int nchk = 0, nfail = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ent_valid[i] = v[i][0];
            ent_rank[i*RANK_W +: RANK_W] = RANK_W'(rk[i]);
            ent_bank[i*BANK_W +: BANK_W] = BANK_W'(bk[i]);
            ent_row[i*ROW_W +: ROW_W] = ROW_W'(rw[i]);
        end
        for (int b = 0; b < NBANK; b++) begin
            bank_row_open[b] = bopen[b][0];
            early_mask[b] = emask[b][0];
            bank_open_row[b*ROW_W +: ROW_W] = ROW_W'(brow[b]);
            bank_free_at[b*TIME_W +: TIME_W] = TIME_W'(bfree[b]);
        end
        now = TIME_W'(tnow);
    end

    req_picker uut (.*);

    function automatic bit ref_hit(int e);
        int id = rk[e] * BPR + bk[e];
        return bopen[id] != 0 && brow[id] == rw[e];
    endfunction

    function automatic bit ref_ready(int e);
        int id = rk[e] * BPR + bk[e];
        return bfree[id] <= tnow || emask[id] != 0;
    endfunction

    function automatic int ref_idx(bit mode);
        int head = -1;
        for (int e = 0; e < DEPTH; e++) if (v[e] != 0 && head < 0) head = e;
        if (mode)
            for (int e = 0; e < DEPTH; e++)
                if (v[e] != 0 && (ref_hit(e) || ref_ready(e))) return e;
        return head;
    endfunction

    function automatic bit ref_mreq(bit mode);
        if (!mode) return 0;
        for (int e = 0; e < DEPTH; e++) if (v[e] != 0 && !ref_hit(e)) return 1;
        return 0;
    endfunction

    task automatic check(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_all();
        tnow = 1000;
        for (int e = 0; e < DEPTH; e++) begin v[e] = 0; rk[e] = 0; bk[e] = e % BPR; rw[e] = 200 + e; end
        for (int b = 0; b < NBANK; b++) begin bopen[b] = 0; brow[b] = 0; bfree[b] = 1100; emask[b] = 0; end
    endtask

    task automatic run(bit mode, string req);
        int ei, any;
        @(negedge clk);
        sched_mode = mode;
        sel_req = 1'b1;
        #1;
        check({req, " R11 mask_req"}, int'(mask_req), int'(ref_mreq(mode)));
        ei = ref_idx(mode);
        any = (ei >= 0);
        @(negedge clk);
        sel_req = 1'b0;
        check({req, " R1 pick_vld"}, int'(pick_vld), any);
        if (any) check({req, " pick_idx"}, int'(pick_idx), ei);
    endtask

    initial begin
        #(200000 * 5);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        int held;
        void'($urandom(32'd1234));
        clear_all();
        #12;
        check("R1 reset pick_vld", int'(pick_vld), 0);
        check("R1 reset pick_idx", int'(pick_idx), 0);
        rst_n = 1'b1;

        // R2 R9: slot 0 invalid, first-come picks slot 1
        clear_all(); v[1] = 1; v[5] = 1; bopen[0] = 1; brow[0] = 200;
        run(1'b0, "R2 R9 first-come");
        check("R2 expected slot", int'(pick_idx), 1);

        // R3: only slot 3 hits
        clear_all(); v[1] = 1; v[3] = 1; v[6] = 1; bopen[3] = 1; brow[3] = 203;
        run(1'b1, "R3 row hit");
        check("R3 expected slot", int'(pick_idx), 3);

        // R10 R8: stored row matches but bank closed -> head
        clear_all(); v[2] = 1; v[4] = 1; brow[0] = 204; bopen[0] = 0;
        run(1'b1, "R10 R8 closed bank");
        check("R10 expected head", int'(pick_idx), 2);

        // R4 R7: free==now at slot 2, hit at slot 5
        clear_all(); v[2] = 1; v[5] = 1; bfree[2] = 1000; bopen[1] = 1; brow[1] = 205;
        run(1'b1, "R4 R7 ready beats younger hit");
        check("R7 expected slot", int'(pick_idx), 2);

        // R5 R6: slot 4 targets rank1 bank2 -> id 6 in mask
        clear_all(); v[1] = 1; v[4] = 1; rk[4] = 1; bk[4] = 2; emask[6] = 1; emask[2] = 0;
        run(1'b1, "R5 R6 early mask");
        check("R6 expected slot", int'(pick_idx), 4);

        // R11: all valid slots hit -> mask_req low
        clear_all(); v[0] = 1; bopen[0] = 1; brow[0] = 200;
        run(1'b1, "R11 all hits");

        // R1: no valid slot
        clear_all();
        held = int'(pick_idx);
        run(1'b1, "R1 empty");
        check("R1 empty idx held", int'(pick_idx), held);

        // R1: no request -> idle, idx held
        clear_all(); v[7] = 1;
        @(negedge clk); @(negedge clk);
        check("R1 idle pick_vld", int'(pick_vld), 0);
        check("R1 idle idx held", int'(pick_idx), held);

        // Random phase
        for (int it = 0; it < 600; it++) begin
            tnow = 100 + int'($urandom % 60000);
            for (int e = 0; e < DEPTH; e++) begin
                v[e] = ($urandom % 3 != 0); rk[e] = $urandom % RANKS;
                bk[e] = $urandom % BPR; rw[e] = $urandom % 4;
            end
            for (int b = 0; b < NBANK; b++) begin
                bopen[b] = ($urandom % 3 == 0); brow[b] = $urandom % 4;
                bfree[b] = tnow + int'($urandom % 8) - 1 + 3 * int'($urandom % 2);
                emask[b] = ($urandom % 6 == 0);
            end
            run(it[0], "R2 R3 R4 R5 R7 R8 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule